// File: doc/BRIEF.md
# Memory Bus Cycle Sequencer for an 8-bit Accumulator Processor

This block produces, one clock at a time, the external bus activity of a handful of memory instructions of a small 8-bit accumulator processor. It covers five operations: a load through a 16-bit base plus index, a direct-page store, a direct-page store with index, a push of the accumulator onto the stack, and an increment in place of a direct-page byte. A decoded operation number, the program counter, the two operand bytes, the index value and the accumulator are presented with a one-cycle start pulse. The block then drives an address, a write strobe, write data and an address-valid qualifier for each bus cycle, and flags the final cycle.

The block reproduces the bus cycles that do no useful work as well as the useful ones. An indexed load that carries into the high byte first issues a throw-away read at an address whose high byte has not been corrected. A direct-page indexed store first reads the unindexed address. A push reads the byte after the opcode. In the legacy mode, an increment in place writes its target twice. The qualifier output is low on every throw-away cycle. Downstream logic can use it to drop those cycles, which gives the same effect as the cleaned-up mode.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset `busy`, `done`, `bus_we` and `bus_vld` are low, `sp` reads 0xFF and `rdata` reads 0x00.
- R2: Operation code 1 (direct-page store) takes 3 bus cycles: reads at pc and pc+1, then a write of `acc` to {0x00, lo} with `done` high.
- R3: Operation code 2 (indexed direct-page store) takes 4 cycles: reads at pc and pc+1, a qualifier-low read at {0x00, lo}, then a write of `acc` to {0x00, (lo+idx) mod 256}. The direct page wraps and never carries into the high byte.
- R4: Operation code 3 (push) takes 3 cycles: a read at pc, a qualifier-low read at pc+1, then a write of `acc` to {0x01, sp}. `sp` drops by one on the clock that follows that write.
- R5: Operation code 0 (indexed load) with no carry out of lo+idx takes 4 cycles: reads at pc, pc+1 and pc+2, then a read of {hi, lo+idx} with `done` high.
- R6: Operation code 0 with a carry out of lo+idx takes 5 cycles. The fourth cycle is a qualifier-low read of {hi, (lo+idx) mod 256}. The fifth reads {hi+1, (lo+idx) mod 256} with `done` high.
- R7: Operation code 4 (increment in place) with `legacy` high takes 5 cycles: reads at pc, pc+1 and {0x00, lo}, then two writes to {0x00, lo}. The first write carries the byte that was read, and the second carries that byte plus one.
- R8: Operation code 4 with `legacy` low takes 5 cycles with a single write. The fourth cycle is a qualifier-low read of {0x00, lo}, and the fifth writes the byte read plus one.
- R9: `bus_vld` is low exactly on the throw-away cycles named in R3, R4, R6 and R8, and every write cycle has `bus_vld` high.
- R10: `start` is ignored while `busy` is high, including in the cycle where `done` is high. Exactly one operation runs per accepted start.
- R11: After an indexed load, `rdata` holds the byte read on its final cycle. `rdata` changes only on the clock after a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| op_code | input | 3 | Operation number (0 to 4) |
| legacy | input | 1 | 1 selects legacy double-write for the increment |
| pc | input | 16 | Address of the opcode byte |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| idx | input | 8 | Index register value |
| acc | input | 8 | Accumulator value to store |
| din | input | 8 | Read data for the current bus cycle |
| bus_addr | output | 16 | Address of the current bus cycle |
| bus_we | output | 1 | 1 for a write cycle |
| bus_dout | output | 8 | Write data |
| bus_vld | output | 1 | Address qualifier, low on throw-away cycles |
| done | output | 1 | Final cycle of the operation |
| busy | output | 1 | An operation is on the bus |
| rdata | output | 8 | Byte returned by the last indexed load |
| sp | output | 8 | Stack pointer |

## Verification
Two events can land on the same cycle: a new start request and the final cycle of the running operation. The bench holds `start` high for the whole of an operation, including its `done` cycle. A queue of expected cycles then reveals any extra or early bus activity, and `busy` must be seen low one cycle later. A second coincidence arises in the indexed load, where the carry out of the low byte determines whether the fourth cycle is the real read or a throw-away read. Both sides of the carry are driven, including lo=0xFF with idx=1, and each cycle's address and qualifier is compared.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int DW = 8;
    localparam int AW = 2 * DW;
    localparam int SW = 3;

    typedef enum logic [2:0] {
        OP_LDX  = 3'd0,
        OP_STZ  = 3'd1,
        OP_STZX = 3'd2,
        OP_PUSH = 3'd3,
        OP_RMW  = 3'd4
    } op_e;

    typedef struct packed {
        logic          busy;
        op_e           op;
        logic [SW-1:0] step;
        logic          legacy;
        logic [AW-1:0] pc;
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        logic [DW-1:0] idx;
        logic [DW-1:0] acc;
        logic [DW-1:0] mdata;
        logic [DW-1:0] sp;
        logic [DW-1:0] rdata;
        logic [AW-1:0] addr;
        logic          we;
        logic [DW-1:0] dout;
        logic          vld;
        logic          last;
    } seq_st_t;
endpackage

// File: rtl/seq_idx_add.sv
module seq_idx_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] ofs,
    output logic [W-1:0] sum,
    output logic         carry
);
    logic [W:0] full;
    assign full  = {1'b0, base} + {1'b0, ofs};
    assign sum   = full[W-1:0];
    assign carry = full[W];
endmodule

// File: rtl/seq_cycle_gen.sv
module seq_cycle_gen
    import seq_pkg::*;
#(
    parameter logic [DW-1:0] STACK_PAGE = 8'h01
) (
    input  op_e           op,
    input  logic [SW-1:0] step,
    input  logic          legacy,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] idx,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] sp,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] mdata,
    output logic [AW-1:0] addr,
    output logic          we,
    output logic [DW-1:0] dout,
    output logic          vld,
    output logic          last
);
    localparam logic [DW-1:0] ZPAGE = '0;

    logic [DW-1:0] isum;
    logic          icarry;

    seq_idx_add #(.W(DW)) u_add (
        .base (lo),
        .ofs  (idx),
        .sum  (isum),
        .carry(icarry)
    );

    always_comb begin
        addr = pc;
        we   = 1'b0;
        dout = '0;
        vld  = 1'b1;
        last = 1'b0;
        unique case (step)
            3'd0: addr = pc;
            3'd1: addr = pc + AW'(1);
            default: begin
                case (op)
                    OP_LDX: begin
                        if (step == 3'd2) begin
                            addr = pc + AW'(2);
                        end else if (step == 3'd3) begin
                            addr = {hi, isum};
                            vld  = ~icarry;
                            last = ~icarry;
                        end else begin
                            addr = {hi + DW'(1), isum};
                            last = 1'b1;
                        end
                    end
                    OP_STZ: begin
                        addr = {ZPAGE, lo};
                        we   = 1'b1;
                        dout = acc;
                        last = 1'b1;
                    end
                    OP_STZX: begin
                        if (step == 3'd2) begin
                            addr = {ZPAGE, lo};
                            vld  = 1'b0;
                        end else begin
                            addr = {ZPAGE, isum};
                            we   = 1'b1;
                            dout = acc;
                            last = 1'b1;
                        end
                    end
                    OP_PUSH: begin
                        addr = {STACK_PAGE, sp};
                        we   = 1'b1;
                        dout = acc;
                        last = 1'b1;
                    end
                    default: begin
                        addr = {ZPAGE, lo};
                        if (step == 3'd3) begin
                            we   = legacy;
                            dout = legacy ? din : '0;
                            vld  = legacy;
                        end else if (step == 3'd4) begin
                            we   = 1'b1;
                            dout = mdata + DW'(1);
                            last = 1'b1;
                        end
                    end
                endcase
            end
        endcase
        if (op == OP_PUSH && step == 3'd1) vld = 1'b0;
    end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import seq_pkg::*;
#(
    parameter logic [DW-1:0] SP_INIT    = 8'hFF,
    parameter logic [DW-1:0] STACK_PAGE = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op_code,
    input  logic          legacy,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] opnd_lo,
    input  logic [DW-1:0] opnd_hi,
    input  logic [DW-1:0] idx,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] bus_addr,
    output logic          bus_we,
    output logic [DW-1:0] bus_dout,
    output logic          bus_vld,
    output logic          done,
    output logic          busy,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] sp
);
    seq_st_t st_q, st_d;

    op_e           g_op;
    logic [SW-1:0] g_step;
    logic          g_legacy;
    logic [AW-1:0] g_pc;
    logic [DW-1:0] g_lo, g_hi, g_idx, g_acc;
    logic [AW-1:0] g_addr;
    logic          g_we, g_vld, g_last;
    logic [DW-1:0] g_dout;

    assign g_op     = st_q.busy ? st_q.op     : op_e'(op_code);
    assign g_step   = st_q.busy ? st_q.step + SW'(1) : '0;
    assign g_legacy = st_q.busy ? st_q.legacy : legacy;
    assign g_pc     = st_q.busy ? st_q.pc     : pc;
    assign g_lo     = st_q.busy ? st_q.lo     : opnd_lo;
    assign g_hi     = st_q.busy ? st_q.hi     : opnd_hi;
    assign g_idx    = st_q.busy ? st_q.idx    : idx;
    assign g_acc    = st_q.busy ? st_q.acc    : acc;

    seq_cycle_gen #(.STACK_PAGE(STACK_PAGE)) u_gen (
        .op    (g_op),
        .step  (g_step),
        .legacy(g_legacy),
        .pc    (g_pc),
        .lo    (g_lo),
        .hi    (g_hi),
        .idx   (g_idx),
        .acc   (g_acc),
        .sp    (st_q.sp),
        .din   (din),
        .mdata (st_q.mdata),
        .addr  (g_addr),
        .we    (g_we),
        .dout  (g_dout),
        .vld   (g_vld),
        .last  (g_last)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy && st_q.last) begin
            st_d.busy = 1'b0;
            st_d.we   = 1'b0;
            st_d.vld  = 1'b0;
            st_d.last = 1'b0;
            if (st_q.op == OP_LDX)  st_d.rdata = din;
            if (st_q.op == OP_PUSH) st_d.sp    = st_q.sp - DW'(1);
        end else if (st_q.busy || start) begin
            if (!st_q.busy) begin
                st_d.busy   = 1'b1;
                st_d.op     = g_op;
                st_d.legacy = legacy;
                st_d.pc     = pc;
                st_d.lo     = opnd_lo;
                st_d.hi     = opnd_hi;
                st_d.idx    = idx;
                st_d.acc    = acc;
            end
            if (st_q.busy && st_q.op == OP_RMW && st_q.step == 3'd2)
                st_d.mdata = din;
            st_d.step = g_step;
            st_d.addr = g_addr;
            st_d.we   = g_we;
            st_d.dout = g_dout;
            st_d.vld  = g_vld;
            st_d.last = g_last;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.sp <= SP_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_addr = st_q.addr;
    assign bus_we   = st_q.we;
    assign bus_dout = st_q.dout;
    assign bus_vld  = st_q.vld;
    assign busy     = st_q.busy;
    assign done     = st_q.busy & st_q.last;
    assign rdata    = st_q.rdata;
    assign sp       = st_q.sp;
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        bus_we,
    input logic        bus_vld,
    input logic [15:0] bus_addr,
    input logic [7:0]  sp,
    input logic [7:0]  rdata
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_vld && !bus_we && !done)); // R1
    AST_WRITE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> bus_vld); // R9
    AST_DOUBLE_WRITE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !done) |=> (bus_we && done && $stable(bus_addr))); // R7
    AST_SP_MOVES_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(sp)); // R4
    AST_RDATA_MOVES_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(rdata)); // R11
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R10
endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .bus_we  (bus_we),
    .bus_vld (bus_vld),
    .bus_addr(bus_addr),
    .sp      (sp),
    .rdata   (rdata)
);

// File: tb/bus_cycle_seq_test.sv
`timescale 1ns/1ps
module bus_cycle_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_code = '0;
    logic        legacy = 1'b0;
    logic [15:0] pc = '0;
    logic [7:0]  opnd_lo = '0, opnd_hi = '0, idx = '0, acc = '0;
    logic [7:0]  din;
    logic [15:0] bus_addr;
    logic        bus_we, bus_vld, done, busy;
    logic [7:0]  bus_dout, rdata, sp;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] a;
        logic        we;
        logic [7:0]  d;
        logic        v;
        logic        dn;
        string       req;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_val(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign din = bus_we ? 8'h00 : mem_val(bus_addr);

    bus_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .legacy(legacy), .pc(pc), .opnd_lo(opnd_lo), .opnd_hi(opnd_hi),
        .idx(idx), .acc(acc), .din(din), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_dout(bus_dout), .bus_vld(bus_vld),
        .done(done), .busy(busy), .rdata(rdata), .sp(sp)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_cyc(input logic [15:0] a, input logic we,
                              input logic [7:0] d, input logic v,
                              input logic dn, input string req);
        exp_t e;
        e.a = a; e.we = we; e.d = d; e.v = v; e.dn = dn; e.req = req;
        q.push_back(e);
    endtask

    // Monitor: pops one expected cycle for every busy cycle
    always @(negedge clk) begin
        if (rst_n && busy) begin
            if (q.size() == 0) begin
                chk(1'b0, "R10", "unexpected bus cycle addr", int'(bus_addr), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(bus_addr == e.a, e.req, "addr", int'(bus_addr), int'(e.a));
                chk(bus_we == e.we, e.req, "we", int'(bus_we), int'(e.we));
                chk(bus_vld == e.v, e.req, "vld", int'(bus_vld), int'(e.v));
                chk(done == e.dn, e.req, "done", int'(done), int'(e.dn));
                if (e.we) chk(bus_dout == e.d, e.req, "dout", int'(bus_dout), int'(e.d));
            end
        end
    end

    task automatic run_op(input logic [2:0] op, input logic leg,
                          input logic [15:0] p, input logic [7:0] lo,
                          input logic [7:0] hi, input logic [7:0] x,
                          input logic [7:0] a, input bit hold);
        @(negedge clk);
        op_code = op; legacy = leg; pc = p; opnd_lo = lo; opnd_hi = hi;
        idx = x; acc = a; start = 1'b1;
        do begin
            @(negedge clk);
            if (!hold) start = 1'b0;
        end while (busy);
        start = 1'b0;
        chk(q.size() == 0, "R10", "missing cycles", q.size(), 0);
        @(negedge clk);
        chk(!busy, "R10", "busy after op", int'(busy), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [8:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done, "R1", "busy/done", int'({busy, done}), 0);
        chk(!bus_we && !bus_vld, "R1", "we/vld", int'({bus_we, bus_vld}), 0);
        chk(sp == 8'hFF, "R1", "sp", int'(sp), 8'hFF);
        chk(rdata == 8'h00, "R1", "rdata", int'(rdata), 0);

        // R2 direct-page store
        expect_cyc(16'h1234, 0, 0, 1, 0, "R2");
        expect_cyc(16'h1235, 0, 0, 1, 0, "R2");
        expect_cyc(16'h0080, 1, 8'h3C, 1, 1, "R2");
        run_op(3'd1, 1'b1, 16'h1234, 8'h80, 8'h00, 8'h00, 8'h3C, 0);

        // R3 indexed direct-page store, wraps in page zero
        expect_cyc(16'h2000, 0, 0, 1, 0, "R3");
        expect_cyc(16'h2001, 0, 0, 1, 0, "R3");
        expect_cyc(16'h00F0, 0, 0, 0, 0, "R3");
        expect_cyc(16'h0010, 1, 8'hA5, 1, 1, "R3");
        run_op(3'd2, 1'b0, 16'h2000, 8'hF0, 8'h00, 8'h20, 8'hA5, 0);

        // R4 two pushes
        expect_cyc(16'h3000, 0, 0, 1, 0, "R4");
        expect_cyc(16'h3001, 0, 0, 0, 0, "R4");
        expect_cyc(16'h01FF, 1, 8'h11, 1, 1, "R4");
        run_op(3'd3, 1'b1, 16'h3000, 8'h00, 8'h00, 8'h00, 8'h11, 0);
        chk(sp == 8'hFE, "R4", "sp after push", int'(sp), 8'hFE);
        expect_cyc(16'h3000, 0, 0, 1, 0, "R4");
        expect_cyc(16'h3001, 0, 0, 0, 0, "R4");
        expect_cyc(16'h01FE, 1, 8'h22, 1, 1, "R4");
        run_op(3'd3, 1'b1, 16'h3000, 8'h00, 8'h00, 8'h00, 8'h22, 0);
        chk(sp == 8'hFD, "R4", "sp after second push", int'(sp), 8'hFD);

        // R5 indexed load, no carry
        s = 9'h010 + 9'h005;
        expect_cyc(16'h4000, 0, 0, 1, 0, "R5");
        expect_cyc(16'h4001, 0, 0, 1, 0, "R5");
        expect_cyc(16'h4002, 0, 0, 1, 0, "R5");
        expect_cyc({8'h40, s[7:0]}, 0, 0, 1, 1, "R5");
        run_op(3'd0, 1'b1, 16'h4000, 8'h10, 8'h40, 8'h05, 8'h00, 0);
        chk(rdata == mem_val({8'h40, s[7:0]}), "R11", "rdata no carry",
            int'(rdata), int'(mem_val({8'h40, s[7:0]})));

        // R6 indexed load across page, R9 qualifier low on spurious read
        expect_cyc(16'h5000, 0, 0, 1, 0, "R6");
        expect_cyc(16'h5001, 0, 0, 1, 0, "R6");
        expect_cyc(16'h5002, 0, 0, 1, 0, "R6");
        expect_cyc(16'h7F00, 0, 0, 0, 0, "R6 R9");
        expect_cyc(16'h8000, 0, 0, 1, 1, "R6");
        run_op(3'd0, 1'b0, 16'h5000, 8'hFF, 8'h7F, 8'h01, 8'h00, 0);
        chk(rdata == mem_val(16'h8000), "R11", "rdata carry",
            int'(rdata), int'(mem_val(16'h8000)));

        // R7 legacy increment in place: double write
        v = mem_val(16'h0044);
        expect_cyc(16'h6000, 0, 0, 1, 0, "R7");
        expect_cyc(16'h6001, 0, 0, 1, 0, "R7");
        expect_cyc(16'h0044, 0, 0, 1, 0, "R7");
        expect_cyc(16'h0044, 1, v, 1, 0, "R7");
        expect_cyc(16'h0044, 1, v + 8'd1, 1, 1, "R7");
        run_op(3'd4, 1'b1, 16'h6000, 8'h44, 8'h00, 8'h00, 8'h00, 0);

        // R8 cleaned-up increment: one write
        expect_cyc(16'h6000, 0, 0, 1, 0, "R8");
        expect_cyc(16'h6001, 0, 0, 1, 0, "R8");
        expect_cyc(16'h0044, 0, 0, 1, 0, "R8");
        expect_cyc(16'h0044, 0, 0, 0, 0, "R8 R9");
        expect_cyc(16'h0044, 1, v + 8'd1, 1, 1, "R8");
        run_op(3'd4, 1'b0, 16'h6000, 8'h44, 8'h00, 8'h00, 8'h00, 0);
        chk(rdata == mem_val(16'h8000), "R11", "rdata kept after increment",
            int'(rdata), int'(mem_val(16'h8000)));

        // R10 start held high through the whole op, including done cycle
        expect_cyc(16'h7000, 0, 0, 1, 0, "R10");
        expect_cyc(16'h7001, 0, 0, 1, 0, "R10");
        expect_cyc(16'h00FF, 1, 8'h77, 1, 1, "R10");
        run_op(3'd1, 1'b0, 16'h7000, 8'hFF, 8'h00, 8'h00, 8'h77, 1);
        chk(sp == 8'hFD, "R10", "sp untouched", int'(sp), 8'hFD);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule